// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block belongs to the model of a parallel NOR-style flash controller. It watches host write cycles, each given as an address, a data word and a one-cycle write strobe. It recognises the software-protected unlock sequences that guard every alteration of the array. Once a sequence is complete, it emits a single-cycle start pulse for one of these operations: program, sector erase, block erase, chip erase, erase suspend, erase resume, query-mode entry or query-mode exit. Alongside the pulse it latches the target address and data.

The block also tracks the operation that is running. An external done input ends a program or erase, because the timing of the array itself lives elsewhere. While an operation runs, the decoder rejects the commands that are not legal at that moment. It remembers the region of a suspended erase, so that a program into that region is refused. A chip erase is honoured only while the write-protect input is high.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every pulse output, busy, in_query and suspended are 0.
- R2: The four writes AAh@555h, 55h@2AAh, A0h@555h and then D@A produce pgm_start high for exactly the cycle after the fourth write. The same cycle shows tgt_addr=A and tgt_data=D, and busy is 1 from that cycle on. Address matching uses only address bits [11:0], and data matching uses only data bits [7:0].
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h and 55h@2AAh, followed by 50h at any address SA, produce sec_erase_start and tgt_addr=SA, and set busy.
- R4: The same five-cycle prefix followed by 30h at address BA produces blk_erase_start and tgt_addr=BA, and sets busy.
- R5: The same prefix followed by 10h@555h produces chip_erase_start and sets busy, but only if wp_n is 1 at that write. If wp_n is 0, the sequence has no effect.
- R6: A write that does not match the step expected by a partly entered sequence returns the decoder to its idle state. The steps already taken are lost.
- R7: While a program or a chip erase runs, every write is ignored, including B0h: no pulse is produced and busy stays 1.
- R8: While a sector or block erase runs, a single write of B0h at any address gives suspend_pulse, clears busy and sets suspended. Every other command is ignored.
- R9: While suspended with no sequence in progress, a single write of 30h at any address gives resume_pulse, sets busy and clears suspended.
- R10: While suspended, a completed program sequence is started only if its address is outside the suspended region. For a sector erase the region is address bits [20:11]; for a block erase it is bits [20:15]. After the suspended program finishes, the decoder returns to the suspended state.
- R11: Query mode is entered either by AAh@555h, 55h@2AAh, 98h@555h or by the single write 98h@055h, and query_enter pulses. In query mode only F0h at any address is acted on: it pulses query_exit and leaves the mode. Every other write is ignored.
- R12: op_done ends a running operation: busy falls in the cycle after op_done is sampled. When nothing runs, op_done has no effect.
- R13: A reset applied during any operation or mode returns the decoder to idle, with busy, suspended and in_query all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W (21) | Write address |
| wr_data | input | DATA_W (16) | Write data; only bits [7:0] are decoded |
| wp_n | input | 1 | Write-protect, low blocks chip erase |
| op_done | input | 1 | Running program or erase has finished |
| pgm_start | output | 1 | Program start pulse |
| sec_erase_start | output | 1 | Sector erase start pulse |
| blk_erase_start | output | 1 | Block erase start pulse |
| chip_erase_start | output | 1 | Chip erase start pulse |
| suspend_pulse | output | 1 | Erase suspended |
| resume_pulse | output | 1 | Erase resumed |
| query_enter | output | 1 | Query mode entered |
| query_exit | output | 1 | Query mode left |
| tgt_addr | output | ADDR_W | Address latched with the last start |
| tgt_data | output | DATA_W | Data latched with the last program |
| busy | output | 1 | A program or erase is running |
| in_query | output | 1 | Query mode active |
| suspended | output | 1 | An erase is suspended |

## Verification
The assertions hold the invariants that must be true on every cycle. At most one start pulse is high at a time. Query mode never coincides with busy. Each start or resume pulse is followed by busy, and a suspend pulse is followed by not-busy with suspended set. A suspend comes only out of a busy state, a chip erase only with write-protect released, and reset always lands in idle. Other behaviour depends on history, and only the bench scenarios show it: the exact unlock order, the abort on a wrong step, the rejection of commands while a program or chip erase runs, and the region guard during suspend. The latched address and data, and the return to the suspended state after a nested program, also need these directed sequences.

// File: rtl/fcd_pkg.sv
// Shared constants and types of the flash command sequence decoder.
// Assumes command codes occupy the low data byte and that unlock
// addresses are matched on a 12-bit window of the address.
package fcd_pkg;

    localparam int CMP_W = 12;
    localparam logic [CMP_W-1:0] ADR_UNLOCK_A = 12'h555;
    localparam logic [CMP_W-1:0] ADR_UNLOCK_B = 12'h2AA;
    localparam logic [CMP_W-1:0] ADR_QRY_ONE  = 12'h055;

    localparam logic [7:0] K_UNLOCK_A = 8'hAA;
    localparam logic [7:0] K_UNLOCK_B = 8'h55;
    localparam logic [7:0] K_PROGRAM  = 8'hA0;
    localparam logic [7:0] K_ERASE    = 8'h80;
    localparam logic [7:0] K_QUERY    = 8'h98;
    localparam logic [7:0] K_CHIP     = 8'h10;
    localparam logic [7:0] K_BLOCK    = 8'h30;
    localparam logic [7:0] K_SECTOR   = 8'h50;
    localparam logic [7:0] K_SUSPEND  = 8'hB0;
    localparam logic [7:0] K_EXIT     = 8'hF0;

    // Flags describing one bus write
    typedef struct packed {
        logic at_a;
        logic at_b;
        logic at_q1;
        logic k_ua;
        logic k_ub;
        logic k_pgm;
        logic k_ers;
        logic k_qry;
        logic k_chip;
        logic k_blk;
        logic k_sec;
        logic k_susp;
        logic k_exit;
    } cyc_t;

    // Position within an unlock sequence
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PDATA, SQ_E3, SQ_E4, SQ_E5
    } seq_e;

    // Operation tracking state
    typedef enum logic [2:0] {
        OP_NONE, OP_PGM, OP_CHIP, OP_ERASE, OP_SUSP, OP_SUSP_PGM
    } op_e;

endpackage

// File: rtl/fcd_cycle_decode.sv
// Classifies one bus write into address and code flags.
// Purely combinational; assumes DATA_W >= 8 and ADDR_W >= CMP_W.
module fcd_cycle_decode
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cyc_t              cyc
);

    logic [CMP_W-1:0] a_lo;
    logic [7:0]       d_lo;

    assign a_lo = addr[CMP_W-1:0];
    assign d_lo = data[7:0];

    // Compare the address window and low data byte against known codes
    always_comb begin
        cyc        = '0;
        cyc.at_a   = (a_lo == ADR_UNLOCK_A);
        cyc.at_b   = (a_lo == ADR_UNLOCK_B);
        cyc.at_q1  = (a_lo == ADR_QRY_ONE);
        cyc.k_ua   = (d_lo == K_UNLOCK_A);
        cyc.k_ub   = (d_lo == K_UNLOCK_B);
        cyc.k_pgm  = (d_lo == K_PROGRAM);
        cyc.k_ers  = (d_lo == K_ERASE);
        cyc.k_qry  = (d_lo == K_QUERY);
        cyc.k_chip = (d_lo == K_CHIP);
        cyc.k_blk  = (d_lo == K_BLOCK);
        cyc.k_sec  = (d_lo == K_SECTOR);
        cyc.k_susp = (d_lo == K_SUSPEND);
        cyc.k_exit = (d_lo == K_EXIT);
    end

endmodule

// File: rtl/fcd_seq.sv
// Unlock sequence walker: steps through the multi-cycle prefixes and
// raises a one-cycle request, combinationally, on the final write.
// Assumes hold is high whenever sequences must not be accepted; any
// mismatching write returns the walker to idle.
module fcd_seq
    import fcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic hold,
    input  cyc_t cyc,
    output logic seq_idle,
    output logic req_pgm,
    output logic req_sec,
    output logic req_blk,
    output logic req_chip,
    output logic req_qry
);

    seq_e state, state_nx;

    assign seq_idle = (state == SQ_IDLE);

    // Next-step and request decode for the current write
    always_comb begin
        state_nx = state;
        req_pgm  = 1'b0;
        req_sec  = 1'b0;
        req_blk  = 1'b0;
        req_chip = 1'b0;
        req_qry  = 1'b0;
        if (hold) begin
            state_nx = SQ_IDLE;
        end else if (wr_en) begin
            state_nx = SQ_IDLE;
            unique case (state)
                SQ_IDLE:  if (cyc.k_ua && cyc.at_a) state_nx = SQ_U1;
                SQ_U1:    if (cyc.k_ub && cyc.at_b) state_nx = SQ_U2;
                SQ_U2: begin
                    if (cyc.at_a && cyc.k_pgm) state_nx = SQ_PDATA;
                    if (cyc.at_a && cyc.k_ers) state_nx = SQ_E3;
                    req_qry = cyc.at_a && cyc.k_qry;
                end
                SQ_PDATA: req_pgm = 1'b1;
                SQ_E3:    if (cyc.k_ua && cyc.at_a) state_nx = SQ_E4;
                SQ_E4:    if (cyc.k_ub && cyc.at_b) state_nx = SQ_E5;
                SQ_E5: begin
                    req_sec  = cyc.k_sec;
                    req_blk  = cyc.k_blk;
                    req_chip = cyc.k_chip && cyc.at_a;
                end
                default:  state_nx = SQ_IDLE;
            endcase
        end
    end

    // Sequence position register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/fcd_op_track.sv
// Operation tracker: accepts or rejects requests from the sequence
// walker according to the running operation, emits registered start
// pulses, latches the target, and guards the suspended erase region.
// Assumes op_done is a level sampled on the clock.
module fcd_op_track
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int SECT_W = 11,
    parameter int BLK_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              wp_n,
    input  logic              op_done,
    input  cyc_t              cyc,
    input  logic              seq_idle,
    input  logic              req_pgm,
    input  logic              req_sec,
    input  logic              req_blk,
    input  logic              req_chip,
    input  logic              req_qry,
    output logic              pgm_start,
    output logic              sec_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic              suspend_pulse,
    output logic              resume_pulse,
    output logic              query_enter,
    output logic              query_exit,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              busy,
    output logic              in_query,
    output logic              suspended
);

    localparam int SREG_W = ADDR_W - SECT_W;
    localparam int BREG_W = ADDR_W - BLK_W;

    op_e               mode, mode_nx;
    logic [ADDR_W-1:0] susp_addr, susp_addr_nx;
    logic              susp_blk, susp_blk_nx;
    logic              qry_nx;
    logic              p_pgm, p_sec, p_blk, p_chip, p_susp, p_res, p_qin, p_qout;
    logic              outside;
    logic              qry_req;

    // Region guard for a program issued during suspend
    always_comb begin
        if (susp_blk)
            outside = (addr[ADDR_W-1:BLK_W] != susp_addr[ADDR_W-1:BLK_W]);
        else
            outside = (addr[ADDR_W-1:SECT_W] != susp_addr[ADDR_W-1:SECT_W]);
    end

    assign qry_req = req_qry || (wr_en && seq_idle && cyc.k_qry && cyc.at_q1);

    // Mode transitions and pulse decisions
    always_comb begin
        mode_nx      = mode;
        susp_addr_nx = susp_addr;
        susp_blk_nx  = susp_blk;
        qry_nx       = in_query;
        {p_pgm, p_sec, p_blk, p_chip, p_susp, p_res, p_qin, p_qout} = '0;
        if (in_query) begin
            if (wr_en && cyc.k_exit) begin
                qry_nx = 1'b0;
                p_qout = 1'b1;
            end
        end else begin
            unique case (mode)
                OP_NONE: begin
                    if (req_pgm) begin
                        mode_nx = OP_PGM;
                        p_pgm   = 1'b1;
                    end else if (req_sec || req_blk) begin
                        mode_nx      = OP_ERASE;
                        susp_addr_nx = addr;
                        susp_blk_nx  = req_blk;
                        p_sec        = req_sec;
                        p_blk        = req_blk;
                    end else if (req_chip && wp_n) begin
                        mode_nx = OP_CHIP;
                        p_chip  = 1'b1;
                    end else if (qry_req) begin
                        qry_nx = 1'b1;
                        p_qin  = 1'b1;
                    end
                end
                OP_PGM, OP_CHIP: if (op_done) mode_nx = OP_NONE;
                OP_ERASE: begin
                    if (op_done) begin
                        mode_nx = OP_NONE;
                    end else if (wr_en && cyc.k_susp) begin
                        mode_nx = OP_SUSP;
                        p_susp  = 1'b1;
                    end
                end
                OP_SUSP: begin
                    if (req_pgm && outside) begin
                        mode_nx = OP_SUSP_PGM;
                        p_pgm   = 1'b1;
                    end else if (wr_en && seq_idle && cyc.k_blk) begin
                        mode_nx = OP_ERASE;
                        p_res   = 1'b1;
                    end else if (qry_req) begin
                        qry_nx = 1'b1;
                        p_qin  = 1'b1;
                    end
                end
                OP_SUSP_PGM: if (op_done) mode_nx = OP_SUSP;
                default: mode_nx = OP_NONE;
            endcase
        end
    end

    // State and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode             <= OP_NONE;
            susp_addr        <= '0;
            susp_blk         <= 1'b0;
            in_query         <= 1'b0;
            pgm_start        <= 1'b0;
            sec_erase_start  <= 1'b0;
            blk_erase_start  <= 1'b0;
            chip_erase_start <= 1'b0;
            suspend_pulse    <= 1'b0;
            resume_pulse     <= 1'b0;
            query_enter      <= 1'b0;
            query_exit       <= 1'b0;
            tgt_addr         <= '0;
            tgt_data         <= '0;
        end else begin
            mode             <= mode_nx;
            susp_addr        <= susp_addr_nx;
            susp_blk         <= susp_blk_nx;
            in_query         <= qry_nx;
            pgm_start        <= p_pgm;
            sec_erase_start  <= p_sec;
            blk_erase_start  <= p_blk;
            chip_erase_start <= p_chip;
            suspend_pulse    <= p_susp;
            resume_pulse     <= p_res;
            query_enter      <= p_qin;
            query_exit       <= p_qout;
            if (p_pgm || p_sec || p_blk || p_chip) tgt_addr <= addr;
            if (p_pgm) tgt_data <= data;
        end
    end

    assign busy      = (mode == OP_PGM) || (mode == OP_CHIP) ||
                       (mode == OP_ERASE) || (mode == OP_SUSP_PGM);
    assign suspended = (mode == OP_SUSP) || (mode == OP_SUSP_PGM);

    // Region widths must leave a non-empty compare field
    initial begin
        if (SREG_W < 1 || BREG_W < 1 || BLK_W < SECT_W)
            $error("fcd_op_track: region widths out of range");
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command sequence decoder: classifies each write,
// walks the unlock sequences, and tracks the running operation.
// Assumes one write per wr_en cycle; synchronous active-low reset.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int SECT_W = 11,
    parameter int BLK_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_n,
    input  logic              op_done,
    output logic              pgm_start,
    output logic              sec_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic              suspend_pulse,
    output logic              resume_pulse,
    output logic              query_enter,
    output logic              query_exit,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              busy,
    output logic              in_query,
    output logic              suspended
);

    cyc_t cyc;
    logic seq_idle, hold;
    logic req_pgm, req_sec, req_blk, req_chip, req_qry;

    assign hold = busy || in_query;

    fcd_cycle_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .cyc  (cyc)
    );

    fcd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .hold     (hold),
        .cyc      (cyc),
        .seq_idle (seq_idle),
        .req_pgm  (req_pgm),
        .req_sec  (req_sec),
        .req_blk  (req_blk),
        .req_chip (req_chip),
        .req_qry  (req_qry)
    );

    fcd_op_track #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SECT_W (SECT_W),
        .BLK_W  (BLK_W)
    ) u_op (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .addr             (wr_addr),
        .data             (wr_data),
        .wp_n             (wp_n),
        .op_done          (op_done),
        .cyc              (cyc),
        .seq_idle         (seq_idle),
        .req_pgm          (req_pgm),
        .req_sec          (req_sec),
        .req_blk          (req_blk),
        .req_chip         (req_chip),
        .req_qry          (req_qry),
        .pgm_start        (pgm_start),
        .sec_erase_start  (sec_erase_start),
        .blk_erase_start  (blk_erase_start),
        .chip_erase_start (chip_erase_start),
        .suspend_pulse    (suspend_pulse),
        .resume_pulse     (resume_pulse),
        .query_enter      (query_enter),
        .query_exit       (query_exit),
        .tgt_addr         (tgt_addr),
        .tgt_data         (tgt_data),
        .busy             (busy),
        .in_query         (in_query),
        .suspended        (suspended)
    );

endmodule

// File: rtl/fcd_checks.sv
// Port-level properties of the flash command sequence decoder,
// attached to every instance of the top through bind.
module fcd_checks (
    input logic clk,
    input logic rst_n,
    input logic wp_n,
    input logic pgm_start,
    input logic sec_erase_start,
    input logic blk_erase_start,
    input logic chip_erase_start,
    input logic suspend_pulse,
    input logic resume_pulse,
    input logic query_enter,
    input logic query_exit,
    input logic busy,
    input logic in_query,
    input logic suspended
);

    // R2
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_start, sec_erase_start, blk_erase_start, chip_erase_start,
                  suspend_pulse, resume_pulse, query_enter, query_exit}));

    // R2
    pgm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |-> busy);

    // R3
    sec_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_erase_start |-> busy && !suspended);

    // R4
    blk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_erase_start |-> busy && !suspended);

    // R5
    chip_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_start |-> $past(wp_n) && busy);

    // R8
    susp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_pulse |-> !busy && suspended && $past(busy));

    // R9
    resume_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> busy && !suspended && $past(suspended));

    // R11
    query_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_query |-> !busy);

    // R13
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !busy && !in_query && !suspended);

endmodule

bind flash_cmd_decoder fcd_checks u_chk (.*);

// File: tb/flash_cmd_decoder_bench.sv
// Directed bench for the flash command sequence decoder.
module flash_cmd_decoder_bench;

    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wp_n = 1'b1;
    logic          op_done = 1'b0;
    logic          pgm_start, sec_erase_start, blk_erase_start, chip_erase_start;
    logic          suspend_pulse, resume_pulse, query_enter, query_exit;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic          busy, in_query, suspended;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle1();
        @(negedge clk);
    endtask

    task automatic done_op();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic unlock();
        wr(21'h555, 16'h00AA);
        wr(21'h2AA, 16'h0055);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(21'h555, 16'h0080);
        unlock();
    endtask

    task automatic program_seq(input logic [AW-1:0] a, input logic [DW-1:0] d);
        unlock();
        wr(21'h555, 16'h00A0);
        wr(a, d);
    endtask

    function automatic logic [7:0] pulses();
        return {pgm_start, sec_erase_start, blk_erase_start, chip_erase_start,
                suspend_pulse, resume_pulse, query_enter, query_exit};
    endfunction

    task automatic t_reset();
        chk("R1 pulses", pulses(), 0);
        chk("R1 busy/query/susp", {busy, in_query, suspended}, 0);
    endtask

    task automatic t_program();
        program_seq(21'h1A_F00, 16'hC35A);
        chk("R2 pgm pulse", pulses(), 8'h80);
        chk("R2 tgt_addr", tgt_addr, 21'h1A_F00);
        chk("R2 tgt_data", tgt_data, 16'hC35A);
        chk("R2 busy", busy, 1);
        idle1();
        chk("R2 single pulse", pgm_start, 0);
        wr(21'h0, 16'h00B0);
        chk("R7 B0 ignored in program", {suspend_pulse, busy}, 2'b01);
        program_seq(21'h10, 16'h1111);
        chk("R7 sequence ignored in program", pulses(), 0);
        chk("R7 target held", tgt_data, 16'hC35A);
        done_op();
        chk("R12 done clears busy", busy, 0);
    endtask

    task automatic t_sector_suspend();
        erase_prefix();
        wr(21'h0C_1234, 16'h0050);
        chk("R3 sector pulse", pulses(), 8'h40);
        chk("R3 tgt_addr", tgt_addr, 21'h0C_1234);
        chk("R3 busy", busy, 1);
        program_seq(21'h1F_0000, 16'h2222);
        chk("R8 program ignored in erase", pulses(), 0);
        wr(21'h3, 16'h00B0);
        chk("R8 suspend pulse", suspend_pulse, 1);
        chk("R8 busy/susp", {busy, suspended}, 2'b01);
        program_seq(21'h0C_1000, 16'h3333);
        chk("R10 inside sector refused", {pgm_start, busy}, 0);
        program_seq(21'h0C_1800, 16'h4444);
        chk("R10 outside sector accepted", pgm_start, 1);
        chk("R10 tgt_data", tgt_data, 16'h4444);
        chk("R10 busy+susp", {busy, suspended}, 2'b11);
        done_op();
        chk("R10 back to suspend", {busy, suspended}, 2'b01);
        wr(21'h7, 16'h0030);
        chk("R9 resume pulse", resume_pulse, 1);
        chk("R9 busy/susp", {busy, suspended}, 2'b10);
        done_op();
        chk("R12 erase done", {busy, suspended}, 0);
    endtask

    task automatic t_block_suspend();
        erase_prefix();
        wr(21'h0A_0000, 16'h0030);
        chk("R4 block pulse", pulses(), 8'h20);
        chk("R4 tgt_addr", tgt_addr, 21'h0A_0000);
        wr(21'h0, 16'h00B0);
        chk("R8 block suspend", suspend_pulse, 1);
        program_seq(21'h0A_4800, 16'h5555);
        chk("R10 inside block refused", {pgm_start, busy}, 0);
        erase_prefix();
        wr(21'h00_0000, 16'h0050);
        chk("R10 erase refused in suspend", pulses(), 0);
        wr(21'h1, 16'h0030);
        chk("R9 block resume", {resume_pulse, busy}, 2'b11);
        done_op();
    endtask

    task automatic t_chip();
        wp_n = 1'b0;
        erase_prefix();
        wr(21'h555, 16'h0010);
        chk("R5 chip refused when protected", {chip_erase_start, busy}, 0);
        wp_n = 1'b1;
        erase_prefix();
        wr(21'h555, 16'h0010);
        chk("R5 chip pulse", pulses(), 8'h10);
        chk("R5 busy", busy, 1);
        wr(21'h0, 16'h00B0);
        chk("R7 B0 ignored in chip erase", {suspend_pulse, suspended, busy}, 3'b001);
        done_op();
        chk("R12 chip done", busy, 0);
    endtask

    task automatic t_abort();
        unlock();
        wr(21'h555, 16'h0012);
        wr(21'h555, 16'h00A0);
        wr(21'h100, 16'h6666);
        chk("R6 bad command aborts", {pgm_start, busy}, 0);
        wr(21'h555, 16'h00AA);
        wr(21'h2AB, 16'h0055);
        wr(21'h555, 16'h00A0);
        wr(21'h100, 16'h6666);
        chk("R6 bad unlock address aborts", {pgm_start, busy}, 0);
        erase_prefix();
        wr(21'h556, 16'h0010);
        chk("R6 chip at wrong address aborts", pulses(), 0);
        program_seq(21'h100, 16'h7777);
        chk("R6 fresh sequence works", pgm_start, 1);
        done_op();
    endtask

    task automatic t_query();
        wr(21'h1F_F055, 16'hAB98);
        chk("R11 single-write entry", {query_enter, in_query}, 2'b11);
        program_seq(21'h200, 16'h8888);
        chk("R11 writes ignored in query", {pulses(), busy}, 0);
        wr(21'h0, 16'h00F0);
        chk("R11 exit", {query_exit, in_query}, 2'b10);
        unlock();
        wr(21'h555, 16'h0098);
        chk("R11 three-write entry", {query_enter, in_query}, 2'b11);
        wr(21'h123, 16'h00F0);
        chk("R11 exit again", in_query, 0);
    endtask

    task automatic t_done_idle();
        done_op();
        chk("R12 done while idle", {busy, suspended, pulses()}, 0);
    endtask

    task automatic t_reset_mid();
        erase_prefix();
        wr(21'h40, 16'h0050);
        wr(21'h0, 16'h00B0);
        wr(21'h055, 16'h0098);
        chk("R13 pre-reset state", {in_query, suspended}, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R13 reset clears", {busy, in_query, suspended}, 0);
        wr(21'h0, 16'h0030);
        chk("R13 no resume after reset", {resume_pulse, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_sector_suspend();
        t_block_suspend();
        t_chip();
        t_abort();
        t_query();
        t_done_idle();
        t_reset_mid();
        idle1();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule